// File: doc/BRIEF.md
# Total-Store-Order Write Buffer with Fences

This block sits between an in-order core's load/store port and a single shared memory port, and it gives the core total-store-order behaviour. A store goes into a small FIFO and the core moves on at once. The FIFO then writes its entries to memory in the background, in the order the core issued them, with one memory write in flight at a time. A load whose address is not held in the FIFO goes straight to memory and may complete before older buffered stores to other addresses reach memory. A load whose address matches one or more buffered stores gets its data from the youngest of those stores and does not touch memory.

Three fence commands let software restore ordering where it needs it. A full fence waits until the buffer has drained and no load is outstanding. A store fence waits only for the buffer to drain. A load fence waits only for the outstanding load to finish. Each fence is held at the command port until its condition is met, so the in-order core cannot issue anything behind it. The memory side is a plain request/acknowledge port. The block holds a request steady until the one-cycle acknowledge arrives, and it returns read data with that acknowledge.

Top module: `tso_wbuf`

## Requirements
- R1: A store command is accepted (`cpu_req_ready` high) in any cycle in which the buffer holds fewer than DEPTH entries, even if memory never acknowledges.
- R2: Buffered stores reach memory in issue order, with one write outstanding. A memory request keeps its valid, address, write flag and data unchanged until `mem_ack`. After a full fence, every address holds the value of its last store.
- R3: While the buffer holds DEPTH entries, a store command is not accepted and stays stalled until an entry drains.
- R4: A load that matches no buffered entry is sent to memory, and its data appears on `cpu_rsp_rdata` with `cpu_rsp_valid` one cycle after the read's `mem_ack`.
- R5: A load that matches buffered stores returns the data of the youngest matching store, with `cpu_rsp_valid` in the cycle after acceptance, and issues no memory read.
- R6: When the memory port is free and both a waiting load and a buffered store are ready to go, the load is issued first. A load can therefore reach memory before older stores to other addresses.
- R7: A full fence (command 2) is accepted only when the buffer is empty, no load is outstanding and the memory port is idle.
- R8: A store fence (command 3) is accepted only when the buffer is empty. An outstanding load does not hold it back.
- R9: A load fence (command 4) is accepted only when no load is outstanding. Buffered stores do not hold it back.
- R10: Only one load is outstanding at a time. A load command is not accepted until the previous load has responded.
- R11: After reset the buffer is empty, no memory request is pending, no response is valid, and a store is accepted at once.

Command encoding on `cpu_req_cmd`: 0 load, 1 store, 2 full fence, 3 store fence, 4 load fence. The remaining codes are accepted and do nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | Core command valid |
| cpu_req_cmd | input | 3 | Command code (see encoding) |
| cpu_req_addr | input | ADDR_W | Load/store word address |
| cpu_req_wdata | input | DATA_W | Store data |
| cpu_req_ready | output | 1 | Command accepted this cycle when high with valid |
| cpu_rsp_valid | output | 1 | One-cycle load response strobe |
| cpu_rsp_rdata | output | DATA_W | Load response data |
| mem_req_valid | output | 1 | Memory request pending |
| mem_req_we | output | 1 | 1 write, 0 read |
| mem_req_addr | output | ADDR_W | Memory address |
| mem_req_wdata | output | DATA_W | Memory write data |
| mem_ack | input | 1 | One-cycle completion of the pending request |
| mem_rdata | input | DATA_W | Read data, valid with mem_ack on reads |

## Verification
The hardest situation to reach is a race for the memory port: a store already in flight, more stores queued behind it, and a load that missed the buffer waiting for that write to finish. The bench gets there by holding the memory model's acknowledge off. It fills the buffer and issues a load to an untouched address, then releases memory and reads the logged request order back. Forwarding is swept over many buffer contents that repeat addresses, with memory still stalled. Any read reaching the port in that window would show up in a counter of read-request cycles.

// File: rtl/tso_wbuf_pkg.sv
package tso_wbuf_pkg;

    typedef enum logic [2:0] {
        CMD_LOAD      = 3'd0,
        CMD_STORE     = 3'd1,
        CMD_FENCE_ALL = 3'd2,
        CMD_FENCE_ST  = 3'd3,
        CMD_FENCE_LD  = 3'd4
    } cmd_e;

    typedef enum logic [1:0] {
        LD_IDLE = 2'd0,   // no load in progress
        LD_WAIT = 2'd1,   // load missed, waiting for the memory port
        LD_MEM  = 2'd2    // load read issued to memory
    } ld_state_e;

endpackage

// File: rtl/tso_store_fifo.sv
module tso_store_fifo #(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_en,
    input  logic [ADDR_W-1:0] push_addr,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop_en,
    output logic [ADDR_W-1:0] head_addr,
    output logic [DATA_W-1:0] head_data,
    output logic [$clog2(DEPTH+1)-1:0] fill,
    input  logic [ADDR_W-1:0] look_addr,
    output logic              look_hit,
    output logic [DATA_W-1:0] look_data
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][ADDR_W-1:0] addr;
        logic [DEPTH-1:0][DATA_W-1:0] data;
        logic [PTR_W-1:0]             rd;
        logic [PTR_W-1:0]             wr;
        logic [CNT_W-1:0]             fill;
    } fifo_t;

    fifo_t fifo_q, fifo_d;

    always_comb begin
        fifo_d = fifo_q;
        if (push_en) begin
            fifo_d.addr[fifo_q.wr] = push_addr;
            fifo_d.data[fifo_q.wr] = push_data;
            fifo_d.wr              = fifo_q.wr + 1'b1;
        end
        if (pop_en) begin
            fifo_d.rd = fifo_q.rd + 1'b1;
        end
        fifo_d.fill = fifo_q.fill + CNT_W'(push_en) - CNT_W'(pop_en);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fifo_q <= '0;
        else        fifo_q <= fifo_d;
    end

    assign head_addr = fifo_q.addr[fifo_q.rd];
    assign head_data = fifo_q.data[fifo_q.rd];
    assign fill      = fifo_q.fill;

    // Per-slot liveness and address compare
    logic [DEPTH-1:0] slot_live;
    logic [DEPTH-1:0] slot_match;

    for (genvar s = 0; s < DEPTH; s++) begin : g_slot
        logic [PTR_W-1:0] age;
        assign age           = PTR_W'(s) - fifo_q.rd;
        assign slot_live[s]  = CNT_W'(age) < fifo_q.fill;
        assign slot_match[s] = slot_live[s] && (fifo_q.addr[s] == look_addr);
    end

    // Walk from oldest to youngest; the last hit wins
    logic [PTR_W-1:0] scan_slot;
    always_comb begin
        look_hit  = 1'b0;
        look_data = '0;
        scan_slot = '0;
        for (int i = 0; i < DEPTH; i++) begin
            scan_slot = fifo_q.rd + PTR_W'(i);
            if (slot_match[scan_slot]) begin
                look_hit  = 1'b1;
                look_data = fifo_q.data[scan_slot];
            end
        end
    end

endmodule

// File: rtl/tso_port_arb.sv
module tso_port_arb (
    input  logic port_busy,
    input  logic ld_waiting,
    input  logic st_pending,
    output logic grant_ld,
    output logic grant_st
);

    // Loads win the free port; stores take it only when no load waits
    assign grant_ld = !port_busy && ld_waiting;
    assign grant_st = !port_busy && !ld_waiting && st_pending;

endmodule

// File: rtl/tso_wbuf.sv
module tso_wbuf
    import tso_wbuf_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req_valid,
    input  logic [2:0]        cpu_req_cmd,
    input  logic [ADDR_W-1:0] cpu_req_addr,
    input  logic [DATA_W-1:0] cpu_req_wdata,
    output logic              cpu_req_ready,
    output logic              cpu_rsp_valid,
    output logic [DATA_W-1:0] cpu_rsp_rdata,
    output logic              mem_req_valid,
    output logic              mem_req_we,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [DATA_W-1:0] mem_req_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata
);

    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        ld_state_e         ld_st;
        logic [ADDR_W-1:0] ld_addr;
        logic              busy;
        logic              m_we;
        logic [ADDR_W-1:0] m_addr;
        logic [DATA_W-1:0] m_wdata;
        logic              rsp_v;
        logic [DATA_W-1:0] rsp_d;
    } ctl_t;

    ctl_t ctl_q, ctl_d;

    cmd_e              cmd;
    logic              accept;
    logic              push_en;
    logic              pop_en;
    logic              ld_acc;
    logic [ADDR_W-1:0] head_addr;
    logic [DATA_W-1:0] head_data;
    logic [CNT_W-1:0]  sq_count;
    logic              fwd_hit;
    logic [DATA_W-1:0] fwd_data;
    logic              ld_busy;
    logic              buf_empty;
    logic              grant_ld;
    logic              grant_st;

    assign cmd       = cmd_e'(cpu_req_cmd);
    assign ld_busy   = (ctl_q.ld_st != LD_IDLE);
    assign buf_empty = (sq_count == '0);

    always_comb begin
        unique case (cmd)
            CMD_LOAD:      cpu_req_ready = !ld_busy;
            CMD_STORE:     cpu_req_ready = (sq_count != CNT_W'(DEPTH));
            CMD_FENCE_ALL: cpu_req_ready = buf_empty && !ld_busy && !ctl_q.busy;
            CMD_FENCE_ST:  cpu_req_ready = buf_empty;
            CMD_FENCE_LD:  cpu_req_ready = !ld_busy;
            default:       cpu_req_ready = 1'b1;
        endcase
    end

    assign accept  = cpu_req_valid && cpu_req_ready;
    assign push_en = accept && (cmd == CMD_STORE);
    assign ld_acc  = accept && (cmd == CMD_LOAD);

    tso_store_fifo #(
        .DEPTH  (DEPTH),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_en   (push_en),
        .push_addr (cpu_req_addr),
        .push_data (cpu_req_wdata),
        .pop_en    (pop_en),
        .head_addr (head_addr),
        .head_data (head_data),
        .fill      (sq_count),
        .look_addr (cpu_req_addr),
        .look_hit  (fwd_hit),
        .look_data (fwd_data)
    );

    tso_port_arb u_arb (
        .port_busy  (ctl_q.busy),
        .ld_waiting (ctl_q.ld_st == LD_WAIT),
        .st_pending (!buf_empty),
        .grant_ld   (grant_ld),
        .grant_st   (grant_st)
    );

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.rsp_v = 1'b0;
        pop_en      = 1'b0;

        // New load from the core: forward or queue for memory
        if (ld_acc) begin
            if (fwd_hit) begin
                ctl_d.rsp_v = 1'b1;
                ctl_d.rsp_d = fwd_data;
            end else begin
                ctl_d.ld_st   = LD_WAIT;
                ctl_d.ld_addr = cpu_req_addr;
            end
        end

        // Completion of the request in flight
        if (ctl_q.busy && mem_ack) begin
            ctl_d.busy = 1'b0;
            if (ctl_q.m_we) begin
                pop_en = 1'b1;
            end else begin
                ctl_d.rsp_v = 1'b1;
                ctl_d.rsp_d = mem_rdata;
                ctl_d.ld_st = LD_IDLE;
            end
        end

        // Launch a new request on a free port
        if (grant_ld) begin
            ctl_d.busy   = 1'b1;
            ctl_d.m_we   = 1'b0;
            ctl_d.m_addr = ctl_q.ld_addr;
            ctl_d.ld_st  = LD_MEM;
        end else if (grant_st) begin
            ctl_d.busy    = 1'b1;
            ctl_d.m_we    = 1'b1;
            ctl_d.m_addr  = head_addr;
            ctl_d.m_wdata = head_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign cpu_rsp_valid = ctl_q.rsp_v;
    assign cpu_rsp_rdata = ctl_q.rsp_d;
    assign mem_req_valid = ctl_q.busy;
    assign mem_req_we    = ctl_q.m_we;
    assign mem_req_addr  = ctl_q.m_addr;
    assign mem_req_wdata = ctl_q.m_wdata;

endmodule

// File: rtl/tso_wbuf_chk.sv
module tso_wbuf_chk #(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       cpu_req_valid,
    input logic [2:0]                 cpu_req_cmd,
    input logic                       cpu_req_ready,
    input logic                       cpu_rsp_valid,
    input logic                       mem_req_valid,
    input logic                       mem_req_we,
    input logic [ADDR_W-1:0]          mem_req_addr,
    input logic [DATA_W-1:0]          mem_req_wdata,
    input logic                       mem_ack,
    input logic [$clog2(DEPTH+1)-1:0] sq_count,
    input logic                       ld_busy,
    input logic                       fwd_hit
);

    localparam int CNT_W = $clog2(DEPTH + 1);

    logic acc;
    assign acc = cpu_req_valid && cpu_req_ready;

    // R1
    a_r1_store_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req_valid && cpu_req_cmd == 3'd1 && sq_count < CNT_W'(DEPTH)) |-> cpu_req_ready);

    // R2
    a_r2_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_ack) |=> (mem_req_valid && $stable(mem_req_we)
            && $stable(mem_req_addr) && $stable(mem_req_wdata)));

    // R3
    a_r3_full_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req_valid && cpu_req_cmd == 3'd1 && sq_count == CNT_W'(DEPTH)) |-> !cpu_req_ready);

    // R4
    a_r4_read_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_ack && !mem_req_we) |=> cpu_rsp_valid);

    // R5
    a_r5_forward_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && cpu_req_cmd == 3'd0 && fwd_hit) |=> (cpu_rsp_valid && !ld_busy));

    // R7
    a_r7_full_fence: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && cpu_req_cmd == 3'd2) |-> (sq_count == '0 && !ld_busy && !mem_req_valid));

    // R8
    a_r8_store_fence: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && cpu_req_cmd == 3'd3) |-> (sq_count == '0));

    // R9
    a_r9_load_fence: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && cpu_req_cmd == 3'd4) |-> !ld_busy);

    // R10
    a_r10_one_load: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && cpu_req_cmd == 3'd0) |-> !ld_busy);

endmodule

bind tso_wbuf tso_wbuf_chk #(
    .DEPTH  (DEPTH),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cpu_req_valid (cpu_req_valid),
    .cpu_req_cmd   (cpu_req_cmd),
    .cpu_req_ready (cpu_req_ready),
    .cpu_rsp_valid (cpu_rsp_valid),
    .mem_req_valid (mem_req_valid),
    .mem_req_we    (mem_req_we),
    .mem_req_addr  (mem_req_addr),
    .mem_req_wdata (mem_req_wdata),
    .mem_ack       (mem_ack),
    .sq_count      (sq_count),
    .ld_busy       (ld_busy),
    .fwd_hit       (fwd_hit)
);

// File: tb/sim_tso_wbuf.sv
module sim_tso_wbuf;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 4;
    localparam int AW         = 4;
    localparam int DW         = 16;
    localparam int NADDR      = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cpu_req_valid = 1'b0;
    logic [2:0]    cpu_req_cmd = 3'd0;
    logic [AW-1:0] cpu_req_addr = '0;
    logic [DW-1:0] cpu_req_wdata = '0;
    logic          cpu_req_ready;
    logic          cpu_rsp_valid;
    logic [DW-1:0] cpu_rsp_rdata;
    logic          mem_req_valid;
    logic          mem_req_we;
    logic [AW-1:0] mem_req_addr;
    logic [DW-1:0] mem_req_wdata;
    logic          mem_ack = 1'b0;
    logic [DW-1:0] mem_rdata = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tso_wbuf #(.DEPTH(DEPTH), .ADDR_W(AW), .DATA_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .cpu_req_valid(cpu_req_valid), .cpu_req_cmd(cpu_req_cmd),
        .cpu_req_addr(cpu_req_addr), .cpu_req_wdata(cpu_req_wdata),
        .cpu_req_ready(cpu_req_ready),
        .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_rdata(cpu_rsp_rdata),
        .mem_req_valid(mem_req_valid), .mem_req_we(mem_req_we),
        .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    int tests = 0;
    int fails = 0;

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // ---------------- memory model ----------------
    logic [DW-1:0] mem [NADDR];
    logic [DW-1:0] shadow [NADDR];
    logic          ack_en = 1'b0;
    int            lat = 0;
    int            lat_cnt = 0;
    int            rd_req_cycles = 0;
    logic          log_we [512];
    logic [AW-1:0] log_addr [512];
    logic [DW-1:0] log_data [512];
    int            log_n = 0;

    initial begin
        for (int i = 0; i < NADDR; i++) begin
            mem[i]    = DW'(16'hA000 + i);
            shadow[i] = DW'(16'hA000 + i);
        end
    end

    always @(negedge clk) begin
        if (mem_req_valid && !mem_req_we) rd_req_cycles <= rd_req_cycles + 1;
        if (mem_ack) begin
            mem_ack <= 1'b0;
        end else if (mem_req_valid && ack_en) begin
            if (lat_cnt >= lat) begin
                lat_cnt  <= 0;
                mem_ack  <= 1'b1;
                log_we[log_n]   <= mem_req_we;
                log_addr[log_n] <= mem_req_addr;
                log_data[log_n] <= mem_req_we ? mem_req_wdata : mem[mem_req_addr];
                log_n <= log_n + 1;
                if (mem_req_we) mem[mem_req_addr] <= mem_req_wdata;
                else            mem_rdata <= mem[mem_req_addr];
            end else begin
                lat_cnt <= lat_cnt + 1;
            end
        end
    end

    // response log
    logic [DW-1:0] rsp_log [64];
    int            rsp_n = 0;
    always @(negedge clk) begin
        if (cpu_rsp_valid) begin
            rsp_log[rsp_n % 64] <= cpu_rsp_rdata;
            rsp_n <= rsp_n + 1;
        end
    end

    // issued stores in program order
    logic [AW-1:0] st_addr [512];
    logic [DW-1:0] st_data [512];
    int            st_n = 0;

    // ---------------- driving tasks ----------------
    task automatic issue(input logic [2:0] c, input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        cpu_req_valid = 1'b1; cpu_req_cmd = c; cpu_req_addr = a; cpu_req_wdata = d;
        #1;
        while (!cpu_req_ready) begin
            @(negedge clk); #1;
        end
        @(posedge clk); #1;
        cpu_req_valid = 1'b0;
    endtask

    task automatic probe(input logic [2:0] c, input logic [AW-1:0] a, output logic rdy);
        @(negedge clk);
        cpu_req_valid = 1'b1; cpu_req_cmd = c; cpu_req_addr = a;
        #1;
        rdy = cpu_req_ready;
        cpu_req_valid = 1'b0;
    endtask

    task automatic do_store(input logic [AW-1:0] a, input logic [DW-1:0] d);
        shadow[a] = d;
        st_addr[st_n] = a; st_data[st_n] = d; st_n++;
        issue(3'd1, a, d);
    endtask

    task automatic do_load(input logic [AW-1:0] a, output logic [DW-1:0] d, output int wait_cyc);
        issue(3'd0, a, '0);
        wait_cyc = 0;
        @(negedge clk);
        while (!cpu_rsp_valid) begin
            @(negedge clk); wait_cyc++;
        end
        d = cpu_rsp_rdata;
    endtask

    // watchdog
    initial begin
        #(CLK_PERIOD * 150000);
        tests++; fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // ---------------- main sequence ----------------
    initial begin
        logic          rdy;
        logic [DW-1:0] rd;
        int            wc;
        int            base;
        int            rsp0;
        int            rdc;

        repeat (3) @(posedge clk);
        @(negedge clk);
        cpu_req_cmd = 3'd1; #1;
        chk("R11 store ready after reset", int'(cpu_req_ready), 1);
        chk("R11 no mem request", int'(mem_req_valid), 0);
        chk("R11 no response", int'(cpu_rsp_valid), 0);
        rst_n = 1'b1;

        // R1/R3: fill with memory stalled
        ack_en = 1'b0;
        for (int j = 0; j < DEPTH; j++) begin
            probe(3'd1, AW'(j + 1), rdy);
            chk("R1 store accepted while not full", int'(rdy), 1);
            do_store(AW'(j + 1), DW'(16'h1100 + j));
        end
        probe(3'd1, 4'd7, rdy);
        chk("R3 store stalls when full", int'(rdy), 0);
        repeat (3) @(negedge clk);
        probe(3'd1, 4'd7, rdy);
        chk("R3 store still stalled", int'(rdy), 0);
        probe(3'd4, 4'd0, rdy);
        chk("R9 load fence passes buffered stores", int'(rdy), 1);
        issue(3'd4, 4'd0, '0);
        probe(3'd3, 4'd0, rdy);
        chk("R8 store fence waits for drain", int'(rdy), 0);
        probe(3'd2, 4'd0, rdy);
        chk("R7 full fence waits for drain", int'(rdy), 0);

        // R6/R4: load miss behind an in-flight store
        base = log_n;
        rsp0 = rsp_n;
        issue(3'd0, 4'd9, '0);
        probe(3'd0, 4'd10, rdy);
        chk("R10 second load stalls", int'(rdy), 0);
        probe(3'd4, 4'd0, rdy);
        chk("R9 load fence waits for load", int'(rdy), 0);
        lat = 1;
        ack_en = 1'b1;
        issue(3'd2, 4'd0, '0);
        #1;
        chk("R7 port idle after full fence", int'(mem_req_valid), 0);
        chk("R6 first access is the in-flight store", int'(log_we[base]), 1);
        chk("R6 load issued next", int'(log_we[base + 1]), 0);
        chk("R6 load address", int'(log_addr[base + 1]), 9);
        for (int j = 2; j <= DEPTH; j++)
            chk("R6 remaining stores after load", int'(log_we[base + j]), 1);
        chk("R4 one response", rsp_n - rsp0, 1);
        chk("R4 load data from memory", int'(rsp_log[rsp0 % 64]), int'(shadow[9]));
        for (int a = 1; a <= DEPTH; a++)
            chk("R2 memory after fence", int'(mem[a]), int'(shadow[a]));

        // R8: store fence with load outstanding, empty buffer
        ack_en = 1'b0;
        issue(3'd0, 4'd10, '0);
        probe(3'd3, 4'd0, rdy);
        chk("R8 store fence ignores pending load", int'(rdy), 1);
        issue(3'd3, 4'd0, '0);
        probe(3'd2, 4'd0, rdy);
        chk("R7 full fence waits for load", int'(rdy), 0);
        rsp0 = rsp_n;
        ack_en = 1'b1;
        issue(3'd4, 4'd0, '0);
        repeat (2) @(negedge clk);
        chk("R4 pending load answered", rsp_n - rsp0, 1);
        chk("R4 pending load data", int'(rsp_log[rsp0 % 64]), int'(shadow[10]));

        // Sweep: forwarding (R5) and drain (R2) over many buffer contents
        for (int n = 1; n <= DEPTH; n++) begin
            for (int k = 0; k < 16; k++) begin
                logic [DEPTH-1:0] used;
                used = '0;
                ack_en = 1'b0;
                lat = k % 3;
                for (int j = 0; j < n; j++) begin
                    int a;
                    a = (k + j * ((k % 3) + 1)) % 4;
                    used[a] = 1'b1;
                    do_store(AW'(a), DW'((n << 12) | (k << 4) | j));
                end
                rdc = rd_req_cycles;
                for (int a = 0; a < 4; a++) begin
                    if (used[a]) begin
                        do_load(AW'(a), rd, wc);
                        chk("R5 forward next cycle", wc, 0);
                        chk("R5 youngest store data", int'(rd), int'(shadow[a]));
                    end
                end
                chk("R5 no memory read on forward", rd_req_cycles - rdc, 0);
                ack_en = 1'b1;
                issue(3'd2, 4'd0, '0);
                for (int a = 0; a < NADDR; a++)
                    chk("R2 memory matches last store", int'(mem[a]), int'(shadow[a]));
                do_load(AW'(4 + (k % 12)), rd, wc);
                chk("R4 miss load data", int'(rd), int'(shadow[4 + (k % 12)]));
            end
        end

        // R2: write order equals issue order
        begin
            int w;
            w = 0;
            for (int i = 0; i < log_n; i++) begin
                if (log_we[i]) begin
                    chk("R2 write order addr", int'(log_addr[i]), int'(st_addr[w]));
                    chk("R2 write order data", int'(log_data[i]), int'(st_data[w]));
                    w++;
                end
            end
            chk("R2 all stores written", w, st_n);
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule